// File: doc/BRIEF.md
# Cascadable Decimal Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit BCD value and, on each rising clock edge, it loads that value from a preset bus, advances it by one, or keeps it. An active-low clear forces the digit to zero at once, without waiting for a clock edge. Two active-high enables must both be high for the digit to advance. Only the second enable takes part in the terminal-count output.

To build a multi-digit decimal counter, place several stages in a chain. The terminal-count output of each stage drives both enables of the next stage. The first stage has its enables held high. Each stage then advances once for every ten advances of the stage below it. The width and the terminal value are parameters. The defaults give a 4-bit decade counter that wraps after nine.

Top module: `decade_stage`

## Requirements
- R1: While mr_n is low, q is 0000 and tc is 0. Both take effect immediately, without a clock edge, and this overrides every other input.
- R2: q changes only at a rising clock edge when mr_n is high. A change of spe_n, pe, te or p between edges leaves q unchanged until the next rising edge.
- R3: If spe_n is low at a rising edge, q takes the value of p. This holds for any values of pe and te.
- R4: If spe_n is high and pe and te are both high at a rising edge, q advances by one. From 1001 it goes to 0000, which gives the sequence 0,1,...,9,0.
- R5: If spe_n is high and pe or te is low at a rising edge, q keeps its value.
- R6: tc is 1 exactly when te is 1 and q is 1001. pe has no effect on tc.
- R7: tc is combinational from q and te. A fall of te drives tc low in the same cycle, with no clock edge.
- R8: A loaded value from 1010 to 1111 advances by plain binary increment, and 1111 goes to 0000. tc stays 0 in all of these states.
- R9: In a chain of three stages, where each tc drives pe and te of the next stage, the chain counts decimal 000 to 999 and wraps to 000. The first-stage tc is high for exactly one clock period in every ten. A load or a clear in the middle of a count acts on every digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge updates q |
| mr_n | input | 1 | Asynchronous clear, active low |
| spe_n | input | 1 | Synchronous preset enable, active low |
| pe | input | 1 | Count enable that does not gate tc |
| te | input | 1 | Count enable that also gates tc |
| p | input | WIDTH (4) | Preset value |
| q | output | WIDTH (4) | Counter value |
| tc | output | 1 | Terminal count: te and q equal to 1001 |

## Verification
Loads, counts and holds change q one rising edge after the inputs are applied. The bench therefore changes inputs at the falling edge and reads q two time units after the next rising edge. tc and the clear act with no clock at all, so those checks lower te or mr_n in the middle of a cycle and read the outputs one time unit later, before any edge. The three-stage chain is read after every edge and compared with a decimal reference count, which shows each carry arriving in the same cycle as the wrap that causes it.

// File: rtl/decade_pkg.sv
package decade_pkg;

   // Operation selected for the next rising edge
   typedef enum logic [1:0] {
      DS_HOLD  = 2'd0,
      DS_COUNT = 2'd1,
      DS_LOAD  = 2'd2
   } ds_mode_e;

endpackage

// File: rtl/dstage_mode_sel.sv
module dstage_mode_sel
   import decade_pkg::*;
(
   input  logic     spe_n,
   input  logic     pe,
   input  logic     te,
   output ds_mode_e mode
);

   // Preset wins over counting; both enables are needed to count
   always_comb begin
      if (!spe_n)
         mode = DS_LOAD;
      else if (pe && te)
         mode = DS_COUNT;
      else
         mode = DS_HOLD;
   end

endmodule

// File: rtl/dstage_next.sv
module dstage_next
   import decade_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int TERM_VAL = 9
) (
   input  logic [WIDTH-1:0] q_cur,
   input  logic [WIDTH-1:0] p,
   input  ds_mode_e         mode,
   output logic [WIDTH-1:0] q_nxt
);

   localparam logic [WIDTH-1:0] TERM_Q  = WIDTH'(TERM_VAL);
   localparam logic [WIDTH-1:0] ONE_Q   = WIDTH'(1);
   localparam int               FULL_V  = (1 << WIDTH) - 1;

   logic [WIDTH-1:0] q_inc;

   generate
      if (TERM_VAL == FULL_V) begin : g_binary
         // Terminal equals all ones: natural wrap suffices
         assign q_inc = q_cur + ONE_Q;
      end else begin : g_modulo
         // Wrap at the terminal value; codes above it roll over naturally
         assign q_inc = (q_cur == TERM_Q) ? '0 : (q_cur + ONE_Q);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         DS_LOAD:  q_nxt = p;
         DS_COUNT: q_nxt = q_inc;
         default:  q_nxt = q_cur;
      endcase
   end

endmodule

// File: rtl/dstage_tc.sv
module dstage_tc #(
   parameter int WIDTH    = 4,
   parameter int TERM_VAL = 9
) (
   input  logic [WIDTH-1:0] q,
   input  logic             te,
   output logic             tc
);

   localparam logic [WIDTH-1:0] TERM_Q = WIDTH'(TERM_VAL);

   // Exact decode; pe deliberately absent
   assign tc = te && (q == TERM_Q);

endmodule

// File: rtl/decade_stage.sv
module decade_stage
   import decade_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter int TERM_VAL = 9
) (
   input  logic             clk,
   input  logic             mr_n,
   input  logic             spe_n,
   input  logic             pe,
   input  logic             te,
   input  logic [WIDTH-1:0] p,
   output logic [WIDTH-1:0] q,
   output logic             tc
);

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("decade_stage: WIDTH must be at least 1");
      end
      if (TERM_VAL < 1 || TERM_VAL > (1 << WIDTH) - 1) begin : g_bad_term
         $error("decade_stage: TERM_VAL must lie in 1 .. 2**WIDTH-1");
      end
   endgenerate

   ds_mode_e         mode;
   logic [WIDTH-1:0] q_nxt;

   dstage_mode_sel u_mode (
      .spe_n (spe_n),
      .pe    (pe),
      .te    (te),
      .mode  (mode)
   );

   dstage_next #(
      .WIDTH    (WIDTH),
      .TERM_VAL (TERM_VAL)
   ) u_next (
      .q_cur (q),
      .p     (p),
      .mode  (mode),
      .q_nxt (q_nxt)
   );

   always_ff @(posedge clk or negedge mr_n) begin
      if (!mr_n)
         q <= '0;
      else
         q <= q_nxt;
   end

   dstage_tc #(
      .WIDTH    (WIDTH),
      .TERM_VAL (TERM_VAL)
   ) u_tc (
      .q  (q),
      .te (te),
      .tc (tc)
   );

endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk #(
   parameter int WIDTH    = 4,
   parameter int TERM_VAL = 9
) (
   input logic             clk,
   input logic             mr_n,
   input logic             spe_n,
   input logic             pe,
   input logic             te,
   input logic [WIDTH-1:0] p,
   input logic [WIDTH-1:0] q,
   input logic             tc
);

   localparam logic [WIDTH-1:0] TERM_Q = WIDTH'(TERM_VAL);
   localparam logic [WIDTH-1:0] ONE_Q  = WIDTH'(1);

   // R1: clear holds the outputs at zero
   p_clear_zero_r1: assert property (@(posedge clk)
      !mr_n |-> (q == '0 && !tc));

   // R3: preset takes p regardless of enables
   p_load_r3: assert property (@(posedge clk) disable iff (!mr_n)
      !spe_n |=> (q == $past(p)));

   // R4: wrap from the terminal value
   p_wrap_r4: assert property (@(posedge clk) disable iff (!mr_n)
      (spe_n && pe && te && q == TERM_Q) |=> (q == '0));

   // R4 / R8: increment elsewhere
   p_step_r4: assert property (@(posedge clk) disable iff (!mr_n)
      (spe_n && pe && te && q != TERM_Q) |=> (q == $past(q) + ONE_Q));

   // R5: hold while an enable is low
   p_hold_r5: assert property (@(posedge clk) disable iff (!mr_n)
      (spe_n && !(pe && te)) |=> $stable(q));

   // R6: tc only at terminal with te high
   p_tc_only_term_r6: assert property (@(posedge clk) disable iff (!mr_n)
      tc |-> (te && q == TERM_Q));

   // R6: tc whenever terminal with te high
   p_tc_when_term_r6: assert property (@(posedge clk) disable iff (!mr_n)
      (te && q == TERM_Q) |-> tc);

endmodule

bind decade_stage decade_stage_chk #(
   .WIDTH    (WIDTH),
   .TERM_VAL (TERM_VAL)
) chk_i (
   .clk   (clk),
   .mr_n  (mr_n),
   .spe_n (spe_n),
   .pe    (pe),
   .te    (te),
   .p     (p),
   .q     (q),
   .tc    (tc)
);

// File: tb/decade_stage_tb_top.sv
module decade_stage_tb_top;

   logic       clk = 1'b0;
   logic       mr_n = 1'b0;
   logic       spe_n = 1'b1;
   logic       pe0 = 1'b0;
   logic       te0 = 1'b0;
   logic [3:0] p0 = 4'd0;
   logic [3:0] p1 = 4'd0;
   logic [3:0] p2 = 4'd0;
   logic [3:0] q0, q1, q2;
   logic       tc0, tc1, tc2;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   decade_stage dut_i (
      .clk (clk), .mr_n (mr_n), .spe_n (spe_n), .pe (pe0), .te (te0),
      .p (p0), .q (q0), .tc (tc0)
   );
   decade_stage stage1_i (
      .clk (clk), .mr_n (mr_n), .spe_n (spe_n), .pe (tc0), .te (tc0),
      .p (p1), .q (q1), .tc (tc1)
   );
   decade_stage stage2_i (
      .clk (clk), .mr_n (mr_n), .spe_n (spe_n), .pe (tc1), .te (tc1),
      .p (p2), .q (q2), .tc (tc2)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // {spe_n, pe, te, p[3:0], exp_q[3:0], exp_tc}
   localparam int NVEC = 13;
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0},  // R3 load, enables low
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0},  // R4
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1},  // R4, R6
      {1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b1},  // R5 hold, R6 pe ignored
      {1'b1, 1'b1, 1'b0, 4'd0,  4'd9,  1'b0},  // R5 hold, R6 te gates
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R4 wrap 9 -> 0
      {1'b0, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0},  // R3 load, enables high
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0},  // R8
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},  // R8
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0},  // R8
      {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R8 15 -> 0
      {1'b0, 1'b0, 1'b0, 4'd9,  4'd9,  1'b0},  // R6 te low
      {1'b0, 1'b0, 1'b1, 4'd9,  4'd9,  1'b1}   // R6 te high, pe low
   };

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int tc_hits;
      int val;
      // R1 reset state
      #3;
      chk("R1 reset q", q0, 0);
      chk("R1 reset tc", tc0, 0);
      @(negedge clk);
      mr_n = 1'b1;

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {spe_n, pe0, te0, p0} = VEC[i][11:5];
         @(posedge clk);
         #2;
         chk($sformatf("R3/R4/R5/R6/R8 vec%0d q", i), q0, int'(VEC[i][4:1]));
         chk($sformatf("R6 vec%0d tc", i), tc0, int'(VEC[i][0]));
      end

      // R7: te falls mid-cycle, tc follows without an edge (q is 9)
      #1;
      te0 = 1'b0;
      #1;
      chk("R7 tc after te fall", tc0, 0);
      te0 = 1'b1;
      #1;
      chk("R7 tc after te rise", tc0, 1);

      // R2: inputs change between edges, q waits for the edge
      @(negedge clk);
      spe_n = 1'b0; p0 = 4'd5;
      #2;
      chk("R2 no change before edge", q0, 9);
      @(posedge clk);
      #2;
      chk("R2 load at edge", q0, 5);

      // R1: clear mid-cycle with load and count requested
      pe0 = 1'b1; te0 = 1'b1; spe_n = 1'b0; p0 = 4'd9;
      #1;
      mr_n = 1'b0;
      #1;
      chk("R1 async clear q", q0, 0);
      chk("R1 async clear tc", tc0, 0);
      @(posedge clk);
      #2;
      chk("R1 clear overrides load", q0, 0);

      // R9: three-stage cascade from 000 through 999 and wrap
      @(negedge clk);
      spe_n = 1'b1; pe0 = 1'b1; te0 = 1'b1;
      mr_n = 1'b1;
      tc_hits = 0;
      for (int n = 1; n <= 1005; n++) begin
         @(posedge clk);
         #2;
         val = n % 1000;
         chk("R9 chain value", int'(q2) * 100 + int'(q1) * 10 + int'(q0), val);
         chk("R9 chain tc0", tc0, ((val % 10) == 9) ? 1 : 0);
         chk("R9 chain tc2", tc2, (val == 999) ? 1 : 0);
         if (n <= 1000 && tc0) tc_hits++;
      end
      chk("R9 tc0 periods per 1000", tc_hits, 100);

      // R9: load in the middle of a count
      @(negedge clk);
      spe_n = 1'b0; p0 = 4'd3; p1 = 4'd4; p2 = 4'd5;
      @(posedge clk);
      #2;
      chk("R9 mid load", int'(q2) * 100 + int'(q1) * 10 + int'(q0), 543);
      @(negedge clk);
      spe_n = 1'b1;
      for (int n = 0; n < 10; n++) @(posedge clk);
      #2;
      chk("R9 count after load", int'(q2) * 100 + int'(q1) * 10 + int'(q0), 553);

      // R9: clear in the middle of a count
      #1;
      mr_n = 1'b0;
      #1;
      chk("R9 mid clear", int'(q2) * 100 + int'(q1) * 10 + int'(q0), 0);
      chk("R9 mid clear tc", int'(tc0) + int'(tc1) + int'(tc2), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule